// File: doc/BRIEF.md
# Contiguity-aware address translation cache

This block is a small fully associative cache of leaf translations for a three-level, 39-bit virtual addressing scheme with 4 KiB base pages. An external table walker hands it leaf entries on a refill port. Each entry comes with the 27-bit virtual page number it translates, the address-space identifier current at walk time, and the table level (0, 1 or 2) at which the leaf was found. The block screens every refilled entry for encodings it must refuse. It reports a fault for those and installs the rest. Level 1 and level 2 leaves are stored as 2 MiB and 1 GiB mappings.

An entry at level 0 may set its contiguity bit (bit 63). It then stands for a naturally aligned 64 KiB block of sixteen base pages and is kept in one slot. The low four virtual page number bits take no part in matching such a slot, and the low four bits of the returned physical page number are taken from the requesting address. A lookup port answers one cycle after each request with hit or miss, the physical page number and the eight flag bits. A flush port drops entries by page, by address space, by both, or all at once.

Top module: `napot_tlb`

## Requirements
- R1: Every lookup request gets exactly one response one cycle later, with `lk_valid` high and exactly one of `lk_hit`/`lk_miss` set. The response reflects the contents before the edge that samples the request. On a miss, `lk_ppn` and `lk_flags` read zero.
- R2: A refill whose entry has any of bits 62:54 set gets `rf_fault` one cycle later and is not installed.
- R3: With `NAPOT_EN` = 0, a refill with bit 63 set faults and is not installed, whatever its other bits are.
- R4: With `NAPOT_EN` = 1, a level-0 refill with bit 63 set is accepted only if PPN bits 3:0 (entry bits 13:10) equal 4'b1000. Any other value faults and is not installed.
- R5: A refill with bit 63 set at level 1 or 2 faults and is not installed.
- R6: A refill faults and is not installed if its V flag (bit 0) is clear, if R (bit 1) and X (bit 3) are both clear, or if W (bit 2) is set with R clear.
- R7: A level-1 refill faults if PPN bits 8:0 are nonzero. A level-2 refill faults if PPN bits 17:0 are nonzero. A level-3 refill always faults.
- R8: An installed contiguous entry hits for every VPN whose bits 26:4 match its tag. The returned PPN is the stored PPN with bits 3:0 replaced by VPN bits 3:0 of the request. A VPN outside the 64 KiB block misses.
- R9: A non-global entry hits only for the ASID given at refill. An entry with G (bit 5) set hits for any ASID.
- R10: A level-1 entry ignores VPN bits 8:0 and a level-2 entry ignores VPN bits 17:0 when matching. Those same low PPN bits come from the request VPN.
- R11: Refills that create a new slot fill the 8 slots in round-robin order starting at slot 0. A refill whose VPN and ASID already hit an installed slot overwrites that slot and does not advance the order.
- R12: A flush with neither selector removes every entry. A page flush removes every entry whose span contains the given VPN, including a whole 64 KiB contiguous entry. An address-space flush removes only non-global entries of that ASID.
- R13: `lk_flags` on a hit returns entry bits 7:0 in the order D, A, G, U, X, W, R, V from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_vpn | input | 27 | Virtual page number to translate |
| lk_asid | input | ASID_W | Address space of the lookup |
| lk_valid | output | 1 | Lookup response present |
| lk_hit | output | 1 | Response is a hit |
| lk_miss | output | 1 | Response is a miss; walker should refill |
| lk_ppn | output | 44 | Translated physical page number |
| lk_flags | output | 8 | Flag bits of the hit entry |
| rf_valid | input | 1 | Refill strobe |
| rf_pte | input | 64 | Leaf entry from the walker |
| rf_vpn | input | 27 | VPN the entry was walked for |
| rf_asid | input | ASID_W | ASID at walk time |
| rf_level | input | 2 | Level where the leaf was found |
| rf_ack | output | 1 | Refill processed (one cycle later) |
| rf_fault | output | 1 | Refill refused as a page fault |
| fl_valid | input | 1 | Flush strobe |
| fl_use_vpn | input | 1 | Restrict flush to one VPN |
| fl_vpn | input | 27 | VPN for a page flush |
| fl_use_asid | input | 1 | Restrict flush to one ASID |
| fl_asid | input | ASID_W | ASID for an address-space flush |

## Verification
The case hardest to reach from the ports is a refill that lands inside a region already held by another slot. A wrong design can allocate a duplicate there, and a duplicate looks correct until replacement order or priority between slots exposes it. The stimulus installs a contiguous entry and refills a different page of the same 64 KiB block with a new PPN. It reads the block back, then fills just enough new pages to wrap the round-robin order. A global entry is placed where a duplicate slot would push it out. Its later survival, and the miss on the contiguous block, show that the overwrite happened in place.

// File: rtl/napot_tlb_pkg.sv
package napot_tlb_pkg;

   localparam int VPN_W  = 27;
   localparam int PPN_W  = 44;
   localparam int PTE_W  = 64;
   localparam int SEG_W  = 9;
   localparam int LVL_W  = 2;
   localparam int NLVL   = 3;
   localparam int FLG_W  = 8;
   localparam int NAP_W  = 4;
   localparam int PPN_LO = 10;

   localparam int V_BIT = 0;
   localparam int R_BIT = 1;
   localparam int W_BIT = 2;
   localparam int X_BIT = 3;
   localparam int G_BIT = 5;

   typedef struct packed {
      logic             vld;
      logic [LVL_W-1:0] lvl;
      logic             nap;
      logic [VPN_W-1:0] tag;
      logic [PPN_W-1:0] ppn;
      logic [FLG_W-1:0] flg;
   } tlb_ent_t;

   // Ones where the VPN passes straight through to the PPN.
   function automatic logic [VPN_W-1:0] span_mask(input logic [LVL_W-1:0] lvl,
                                                  input logic nap);
      logic [VPN_W-1:0] m;
      m = '0;
      for (int s = 0; s < NLVL; s++) begin
         if (int'(lvl) > s) m[s*SEG_W +: SEG_W] = '1;
      end
      if (nap) m[NAP_W-1:0] = '1;
      return m;
   endfunction

endpackage

// File: rtl/napot_tlb_pte_check.sv
module napot_tlb_pte_check
   import napot_tlb_pkg::*;
#(
   parameter bit NAPOT_EN = 1'b1
)(
   input  logic [PTE_W-1:0] pte,
   input  logic [LVL_W-1:0] lvl,
   output logic             fault,
   output logic             nap
);

   localparam int N_BIT  = PTE_W - 1;
   localparam int RSV_HI = PTE_W - 2;
   localparam int RSV_LO = PPN_LO + PPN_W;
   localparam logic [NAP_W-1:0] NAP_CODE = NAP_W'(1) << (NAP_W - 1);
   localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(NLVL - 1);

   logic [VPN_W-1:0] ppn_lo;
   logic rsv_bad, lvl_bad, perm_bad, misal, n_bad;
   logic unused_bits;

   assign ppn_lo   = pte[PPN_LO +: VPN_W];
   assign rsv_bad  = |pte[RSV_HI:RSV_LO];
   assign lvl_bad  = lvl > LVL_TOP;
   assign perm_bad = !pte[V_BIT]
                   || (!pte[R_BIT] && !pte[X_BIT])
                   || (pte[W_BIT] && !pte[R_BIT]);
   assign misal    = |(ppn_lo & span_mask(lvl, 1'b0));
   assign unused_bits = ^{pte[RSV_LO-1:PPN_LO+VPN_W], pte[PPN_LO-1:X_BIT+1]};

   generate
      if (NAPOT_EN) begin : g_nap
         assign n_bad = pte[N_BIT] && ((lvl != '0) || (ppn_lo[NAP_W-1:0] != NAP_CODE));
         assign nap   = pte[N_BIT] && !n_bad;
      end else begin : g_nonap
         assign n_bad = pte[N_BIT];
         assign nap   = 1'b0;
      end
   endgenerate

   assign fault = rsv_bad || lvl_bad || perm_bad || misal || n_bad;

endmodule

// File: rtl/napot_tlb_cmp.sv
module napot_tlb_cmp
   import napot_tlb_pkg::*;
#(
   parameter int ASID_W = 16
)(
   input  tlb_ent_t          ent,
   input  logic [ASID_W-1:0] ent_asid,
   input  logic [VPN_W-1:0]  q_vpn,
   input  logic [ASID_W-1:0] q_asid,
   output logic              vpn_hit,
   output logic              asid_eq,
   output logic              glob
);

   logic [VPN_W-1:0] m;
   logic unused_ent;

   assign m          = span_mask(ent.lvl, ent.nap);
   assign vpn_hit    = ent.vld && (((ent.tag ^ q_vpn) & ~m) == '0);
   assign asid_eq    = ent_asid == q_asid;
   assign glob       = ent.flg[G_BIT];
   assign unused_ent = ^{ent.ppn, ent.flg};

endmodule

// File: rtl/napot_tlb_victim.sv
module napot_tlb_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               install,
   input  logic [ENTRIES-1:0] reuse_vec,
   output logic [IDX_W-1:0]   slot
);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] reuse_idx;
   logic             reuse_any;

   always_comb begin
      reuse_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (reuse_vec[i]) reuse_idx = IDX_W'(i);
      end
   end

   assign reuse_any = |reuse_vec;
   assign slot      = reuse_any ? reuse_idx : ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (install && !reuse_any) begin
         ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

endmodule

// File: rtl/napot_tlb.sv
module napot_tlb
   import napot_tlb_pkg::*;
#(
   parameter int ENTRIES  = 8,
   parameter int ASID_W   = 16,
   parameter bit NAPOT_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_valid,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [FLG_W-1:0]  lk_flags,
   input  logic              rf_valid,
   input  logic [PTE_W-1:0]  rf_pte,
   input  logic [VPN_W-1:0]  rf_vpn,
   input  logic [ASID_W-1:0] rf_asid,
   input  logic [LVL_W-1:0]  rf_level,
   output logic              rf_ack,
   output logic              rf_fault,
   input  logic              fl_valid,
   input  logic              fl_use_vpn,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic              fl_use_asid,
   input  logic [ASID_W-1:0] fl_asid
);

   localparam int IDX_W = $clog2(ENTRIES);

   generate
      if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
         $error("napot_tlb: ENTRIES must lie in 2..64");
      end
      if (ASID_W < 1 || ASID_W > 16) begin : g_bad_asid
         $error("napot_tlb: ASID_W must lie in 1..16");
      end
   endgenerate

   tlb_ent_t          ent_q  [ENTRIES];
   logic [ASID_W-1:0] asid_q [ENTRIES];

   logic [ENTRIES-1:0] lk_match, rf_match, fl_kill;

   // Per-slot comparators for the three query ports
   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
         logic lk_vh, lk_ae, lk_g;
         logic rf_vh, rf_ae, rf_g;
         logic fl_vh, fl_ae, fl_g;

         napot_tlb_cmp #(.ASID_W(ASID_W)) u_lk_cmp (
            .ent(ent_q[i]), .ent_asid(asid_q[i]), .q_vpn(lk_vpn), .q_asid(lk_asid),
            .vpn_hit(lk_vh), .asid_eq(lk_ae), .glob(lk_g));
         napot_tlb_cmp #(.ASID_W(ASID_W)) u_rf_cmp (
            .ent(ent_q[i]), .ent_asid(asid_q[i]), .q_vpn(rf_vpn), .q_asid(rf_asid),
            .vpn_hit(rf_vh), .asid_eq(rf_ae), .glob(rf_g));
         napot_tlb_cmp #(.ASID_W(ASID_W)) u_fl_cmp (
            .ent(ent_q[i]), .ent_asid(asid_q[i]), .q_vpn(fl_vpn), .q_asid(fl_asid),
            .vpn_hit(fl_vh), .asid_eq(fl_ae), .glob(fl_g));

         assign lk_match[i] = lk_vh && (lk_g || lk_ae);
         assign rf_match[i] = rf_vh && (rf_g || rf_ae);
         assign fl_kill[i]  = fl_valid
                            && (!fl_use_vpn || fl_vh)
                            && (!fl_use_asid || (!fl_g && fl_ae));
      end
   endgenerate

   // Lookup: lowest matching slot wins
   tlb_ent_t         sel;
   logic             sel_any;
   logic [VPN_W-1:0] sel_m;
   logic [PPN_W-1:0] sel_ppn;

   always_comb begin
      sel     = '0;
      sel_any = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_match[i]) begin
            sel     = ent_q[i];
            sel_any = 1'b1;
         end
      end
   end

   assign sel_m   = span_mask(sel.lvl, sel.nap);
   assign sel_ppn = {sel.ppn[PPN_W-1:VPN_W], (sel.ppn[VPN_W-1:0] & ~sel_m) | (lk_vpn & sel_m)};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_valid <= 1'b0;
         lk_hit   <= 1'b0;
         lk_miss  <= 1'b0;
         lk_ppn   <= '0;
         lk_flags <= '0;
      end else begin
         lk_valid <= lk_req;
         lk_hit   <= lk_req && sel_any;
         lk_miss  <= lk_req && !sel_any;
         lk_ppn   <= (lk_req && sel_any) ? sel_ppn : '0;
         lk_flags <= (lk_req && sel_any) ? sel.flg : '0;
      end
   end

   // Refill screening and placement
   logic             chk_fault, chk_nap, install;
   logic [IDX_W-1:0] slot;
   tlb_ent_t         new_ent;

   napot_tlb_pte_check #(.NAPOT_EN(NAPOT_EN)) u_pte_check (
      .pte(rf_pte), .lvl(rf_level), .fault(chk_fault), .nap(chk_nap));

   assign install = rf_valid && !chk_fault;

   napot_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .install(install), .reuse_vec(rf_match), .slot(slot));

   always_comb begin
      new_ent.vld = 1'b1;
      new_ent.lvl = rf_level;
      new_ent.nap = chk_nap;
      new_ent.tag = rf_vpn;
      new_ent.ppn = rf_pte[PPN_LO +: PPN_W];
      new_ent.flg = rf_pte[FLG_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rf_ack   <= 1'b0;
         rf_fault <= 1'b0;
      end else begin
         rf_ack   <= rf_valid;
         rf_fault <= rf_valid && chk_fault;
      end
   end

   // Storage: flush first, then a same-cycle refill claims its slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            ent_q[i]  <= '0;
            asid_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (fl_kill[i]) ent_q[i].vld <= 1'b0;
            if (install && slot == IDX_W'(i)) begin
               ent_q[i]  <= new_ent;
               asid_q[i] <= rf_asid;
            end
         end
      end
   end

endmodule

// File: rtl/napot_tlb_chk.sv
module napot_tlb_chk
   import napot_tlb_pkg::*;
#(
   parameter bit NAPOT_EN = 1'b1
)(
   input logic             clk,
   input logic             rst_n,
   input logic             lk_req,
   input logic             lk_valid,
   input logic             lk_hit,
   input logic             lk_miss,
   input logic [FLG_W-1:0] lk_flags,
   input logic             rf_valid,
   input logic [PTE_W-1:0] rf_pte,
   input logic [LVL_W-1:0] rf_level,
   input logic             rf_ack,
   input logic             rf_fault,
   input logic             fl_valid,
   input logic             fl_use_vpn,
   input logic             fl_use_asid
);

   logic empty_q;
   logic unused_chk;

   assign unused_chk = ^{rf_pte, lk_flags};

   always_ff @(posedge clk) begin
      if (!rst_n) empty_q <= 1'b1;
      else if (rf_valid) empty_q <= 1'b0;
      else if (fl_valid && !fl_use_vpn && !fl_use_asid) empty_q <= 1'b1;
   end

   p_resp_next_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_valid);
   p_no_stray_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !lk_valid);
   p_hit_xor_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (lk_hit ^ lk_miss));
   p_refill_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rf_valid |=> rf_ack);
   p_rsv_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && |rf_pte[PTE_W-2:PPN_LO+PPN_W]) |=> rf_fault);
   p_nap_level_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && rf_pte[PTE_W-1] && rf_level != '0) |=> rf_fault);
   p_invalid_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && !rf_pte[V_BIT]) |=> rf_fault);
   p_hit_has_v_r13: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_flags[V_BIT]);
   p_empty_misses_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && empty_q) |=> lk_miss);

   generate
      if (!NAPOT_EN) begin : g_off
         p_nbit_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rf_valid && rf_pte[PTE_W-1]) |=> rf_fault);
      end
   endgenerate

endmodule

bind napot_tlb napot_tlb_chk #(.NAPOT_EN(NAPOT_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_valid(lk_valid), .lk_hit(lk_hit),
   .lk_miss(lk_miss), .lk_flags(lk_flags), .rf_valid(rf_valid), .rf_pte(rf_pte),
   .rf_level(rf_level), .rf_ack(rf_ack), .rf_fault(rf_fault), .fl_valid(fl_valid),
   .fl_use_vpn(fl_use_vpn), .fl_use_asid(fl_use_asid));

// File: tb/test_napot_tlb.sv
`timescale 1ns/1ps
module test_napot_tlb;
   import napot_tlb_pkg::*;

   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              lk_req = 0, lk_valid, lk_hit, lk_miss;
   logic [VPN_W-1:0]  lk_vpn = '0;
   logic [AW-1:0]     lk_asid = '0;
   logic [PPN_W-1:0]  lk_ppn;
   logic [FLG_W-1:0]  lk_flags;
   logic              rf_valid = 0, rf_ack, rf_fault;
   logic [PTE_W-1:0]  rf_pte = '0;
   logic [VPN_W-1:0]  rf_vpn = '0;
   logic [AW-1:0]     rf_asid = '0;
   logic [LVL_W-1:0]  rf_level = '0;
   logic              fl_valid = 0, fl_use_vpn = 0, fl_use_asid = 0;
   logic [VPN_W-1:0]  fl_vpn = '0;
   logic [AW-1:0]     fl_asid = '0;

   // instance with contiguity support disabled
   logic              b_lk_req = 0, b_lk_valid, b_lk_hit, b_lk_miss;
   logic [VPN_W-1:0]  b_lk_vpn = '0;
   logic [PPN_W-1:0]  b_lk_ppn;
   logic [FLG_W-1:0]  b_lk_flags;
   logic              b_rf_valid = 0, b_rf_ack, b_rf_fault;
   logic [PTE_W-1:0]  b_rf_pte = '0;
   logic [VPN_W-1:0]  b_rf_vpn = '0;

   int n_vec = 0;
   int n_bad = 0;

   typedef struct {
      logic             hit;
      logic [PPN_W-1:0] ppn;
      logic [FLG_W-1:0] flg;
      string            req;
   } exp_t;
   exp_t sb[$];

   napot_tlb #(.ENTRIES(8), .ASID_W(AW), .NAPOT_EN(1'b1)) i_napot_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_valid(lk_valid),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_flags(lk_flags),
      .rf_valid(rf_valid), .rf_pte(rf_pte), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
      .rf_level(rf_level), .rf_ack(rf_ack), .rf_fault(rf_fault),
      .fl_valid(fl_valid), .fl_use_vpn(fl_use_vpn), .fl_vpn(fl_vpn),
      .fl_use_asid(fl_use_asid), .fl_asid(fl_asid));

   napot_tlb #(.ENTRIES(8), .ASID_W(AW), .NAPOT_EN(1'b0)) i_napot_tlb_off (
      .clk(clk), .rst_n(rst_n),
      .lk_req(b_lk_req), .lk_vpn(b_lk_vpn), .lk_asid(16'd5), .lk_valid(b_lk_valid),
      .lk_hit(b_lk_hit), .lk_miss(b_lk_miss), .lk_ppn(b_lk_ppn), .lk_flags(b_lk_flags),
      .rf_valid(b_rf_valid), .rf_pte(b_rf_pte), .rf_vpn(b_rf_vpn), .rf_asid(16'd5),
      .rf_level(2'd0), .rf_ack(b_rf_ack), .rf_fault(b_rf_fault),
      .fl_valid(1'b0), .fl_use_vpn(1'b0), .fl_vpn('0),
      .fl_use_asid(1'b0), .fl_asid('0));

   function automatic logic [PTE_W-1:0] mkpte(input logic n, input logic [8:0] rsv,
                                              input logic [PPN_W-1:0] ppn,
                                              input logic [FLG_W-1:0] f);
      return {n, rsv, ppn, 2'b00, f};
   endfunction

   task automatic report();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // Driver: push expectation, pulse request
   task automatic lookup(input logic [VPN_W-1:0] v, input logic [AW-1:0] a,
                         input logic hit, input logic [PPN_W-1:0] p,
                         input logic [FLG_W-1:0] f, input string r);
      exp_t e;
      e.hit = hit; e.ppn = hit ? p : '0; e.flg = hit ? f : '0; e.req = r;
      @(negedge clk);
      lk_req = 1'b1; lk_vpn = v; lk_asid = a;
      sb.push_back(e);
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   // Monitor: pop and compare each response
   always @(negedge clk) begin
      if (rst_n && lk_valid) begin
         n_vec++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL R1: unexpected response hit=%0b, expected none", lk_hit);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (lk_hit !== e.hit || lk_miss !== !e.hit || lk_ppn !== e.ppn || lk_flags !== e.flg) begin
               n_bad++;
               $display("FAIL %s: hit=%0b miss=%0b ppn=%h flags=%h, expected hit=%0b ppn=%h flags=%h",
                        e.req, lk_hit, lk_miss, lk_ppn, lk_flags, e.hit, e.ppn, e.flg);
            end
         end
      end
   end

   task automatic refill(input logic [PTE_W-1:0] pte, input logic [VPN_W-1:0] v,
                         input logic [AW-1:0] a, input logic [LVL_W-1:0] lvl,
                         input logic exp_fault, input string r);
      @(negedge clk);
      rf_valid = 1'b1; rf_pte = pte; rf_vpn = v; rf_asid = a; rf_level = lvl;
      @(negedge clk);
      rf_valid = 1'b0;
      n_vec++;
      if (rf_ack !== 1'b1 || rf_fault !== exp_fault) begin
         n_bad++;
         $display("FAIL %s: ack=%0b fault=%0b, expected ack=1 fault=%0b", r, rf_ack, rf_fault, exp_fault);
      end
   endtask

   task automatic flush(input logic uv, input logic [VPN_W-1:0] v,
                        input logic ua, input logic [AW-1:0] a);
      @(negedge clk);
      fl_valid = 1'b1; fl_use_vpn = uv; fl_vpn = v; fl_use_asid = ua; fl_asid = a;
      @(negedge clk);
      fl_valid = 1'b0;
   endtask

   task automatic b_refill(input logic [PTE_W-1:0] pte, input logic [VPN_W-1:0] v,
                           input logic exp_fault, input string r);
      @(negedge clk);
      b_rf_valid = 1'b1; b_rf_pte = pte; b_rf_vpn = v;
      @(negedge clk);
      b_rf_valid = 1'b0;
      n_vec++;
      if (b_rf_ack !== 1'b1 || b_rf_fault !== exp_fault) begin
         n_bad++;
         $display("FAIL %s: ack=%0b fault=%0b, expected ack=1 fault=%0b", r, b_rf_ack, b_rf_fault, exp_fault);
      end
   endtask

   task automatic b_lookup(input logic [VPN_W-1:0] v, input logic hit,
                           input logic [PPN_W-1:0] p, input string r);
      @(negedge clk);
      b_lk_req = 1'b1; b_lk_vpn = v;
      @(negedge clk);
      b_lk_req = 1'b0;
      n_vec++;
      if (b_lk_valid !== 1'b1 || b_lk_hit !== hit || (hit && b_lk_ppn !== p)) begin
         n_bad++;
         $display("FAIL %s: valid=%0b hit=%0b ppn=%h, expected valid=1 hit=%0b ppn=%h",
                  r, b_lk_valid, b_lk_hit, b_lk_ppn, hit, p);
      end
   endtask

   initial begin
      #(8ns * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
      $finish;
   end

   localparam logic [FLG_W-1:0] F_USR = 8'h57;  // A U W R V
   localparam logic [FLG_W-1:0] F_GLB = 8'h77;  // plus G

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if (lk_valid !== 1'b0 || rf_ack !== 1'b0 || rf_fault !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: reset outputs valid=%0b ack=%0b fault=%0b, expected 0 0 0",
                  lk_valid, rf_ack, rf_fault);
      end
      lookup(27'h00000, 16'd5, 1'b0, '0, '0, "R1 empty after reset");

      // R2 reserved bits
      refill(mkpte(1'b0, 9'h001, 44'h1000, F_USR), 27'h00100, 16'd5, 2'd0, 1'b1, "R2 reserved bit");
      lookup(27'h00100, 16'd5, 1'b0, '0, '0, "R2 not installed");
      // R6 permissions
      refill(mkpte(1'b0, 9'h0, 44'h1000, 8'h56), 27'h00101, 16'd5, 2'd0, 1'b1, "R6 V clear");
      refill(mkpte(1'b0, 9'h0, 44'h1000, 8'h55), 27'h00102, 16'd5, 2'd0, 1'b1, "R6 W without R");
      refill(mkpte(1'b0, 9'h0, 44'h1000, 8'h51), 27'h00103, 16'd5, 2'd0, 1'b1, "R6 no R no X");
      lookup(27'h00101, 16'd5, 1'b0, '0, '0, "R6 not installed");
      // R4 contiguity nibble
      refill(mkpte(1'b1, 9'h0, 44'hABCD4, F_USR), 27'h12340, 16'd5, 2'd0, 1'b1, "R4 nibble 0100");
      refill(mkpte(1'b1, 9'h0, 44'hABCD9, F_USR), 27'h12340, 16'd5, 2'd0, 1'b1, "R4 nibble 1001");
      lookup(27'h12345, 16'd5, 1'b0, '0, '0, "R4 not installed");
      // R5 contiguity above level 0
      refill(mkpte(1'b1, 9'h0, 44'hA000, F_USR), 27'h00600, 16'd5, 2'd1, 1'b1, "R5 N at level 1");
      refill(mkpte(1'b1, 9'h0, 44'h40000, F_USR), 27'h0C0000, 16'd5, 2'd2, 1'b1, "R5 N at level 2");
      // R7 alignment and level
      refill(mkpte(1'b0, 9'h0, 44'hA001, F_USR), 27'h00600, 16'd5, 2'd1, 1'b1, "R7 misaligned level 1");
      refill(mkpte(1'b0, 9'h0, 44'h1000, F_USR), 27'h00100, 16'd5, 2'd3, 1'b1, "R7 level 3");
      lookup(27'h006AB, 16'd5, 1'b0, '0, '0, "R7 not installed");

      // R8 contiguous entry (slot 0)
      refill(mkpte(1'b1, 9'h0, 44'hABCD8, F_USR), 27'h12340, 16'd5, 2'd0, 1'b0, "R8 install");
      lookup(27'h12345, 16'd5, 1'b1, 44'hABCD5, F_USR, "R8 low nibble 5");
      lookup(27'h1234F, 16'd5, 1'b1, 44'hABCDF, F_USR, "R8 low nibble F");
      lookup(27'h12340, 16'd5, 1'b1, 44'hABCD0, F_USR, "R8 low nibble 0 R13");
      lookup(27'h12350, 16'd5, 1'b0, '0, '0, "R8 outside block");
      // R9 ASID and global (slot 1)
      lookup(27'h12345, 16'd6, 1'b0, '0, '0, "R9 other ASID");
      refill(mkpte(1'b0, 9'h0, 44'h5555, F_GLB), 27'h20777, 16'd5, 2'd0, 1'b0, "R9 global install");
      lookup(27'h20777, 16'd9, 1'b1, 44'h5555, F_GLB, "R9 global any ASID");
      // R10 superpages (slots 2, 3)
      refill(mkpte(1'b0, 9'h0, 44'hA000, F_USR), 27'h00600, 16'd5, 2'd1, 1'b0, "R10 level 1 install");
      refill(mkpte(1'b0, 9'h0, 44'h40000, F_USR), 27'h0C0000, 16'd5, 2'd2, 1'b0, "R10 level 2 install");
      lookup(27'h006AB, 16'd5, 1'b1, 44'hA0AB, F_USR, "R10 level 1 hit");
      lookup(27'h00800, 16'd5, 1'b0, '0, '0, "R10 level 1 outside");
      lookup(27'h0C1234, 16'd5, 1'b1, 44'h41234, F_USR, "R10 level 2 hit");

      // R11 overwrite in place, then wrap the round-robin order
      refill(mkpte(1'b1, 9'h0, 44'hBBBB8, F_USR), 27'h12348, 16'd5, 2'd0, 1'b0, "R11 overlap refill");
      lookup(27'h12341, 16'd5, 1'b1, 44'hBBBB1, F_USR, "R11 overwrite visible");
      for (int k = 0; k < 4; k++)
         refill(mkpte(1'b0, 9'h0, 44'h100 + 44'(k), F_USR), 27'h30000 + 27'(k), 16'd5, 2'd0, 1'b0, "R11 fill");
      refill(mkpte(1'b0, 9'h0, 44'h110, F_USR), 27'h30010, 16'd5, 2'd0, 1'b0, "R11 wrap");
      lookup(27'h12341, 16'd5, 1'b0, '0, '0, "R11 slot 0 evicted");
      lookup(27'h20777, 16'd5, 1'b1, 44'h5555, F_GLB, "R11 slot 1 kept");
      lookup(27'h30003, 16'd5, 1'b1, 44'h103, F_USR, "R11 slot 7 kept");

      // R12 flushes
      flush(1'b0, '0, 1'b1, 16'd9);
      lookup(27'h30003, 16'd5, 1'b1, 44'h103, F_USR, "R12 other ASID flush keeps");
      flush(1'b0, '0, 1'b1, 16'd5);
      lookup(27'h20777, 16'd5, 1'b1, 44'h5555, F_GLB, "R12 global survives ASID flush");
      lookup(27'h30003, 16'd5, 1'b0, '0, '0, "R12 ASID flush removes");
      lookup(27'h006AB, 16'd5, 1'b0, '0, '0, "R12 ASID flush removes superpage");
      refill(mkpte(1'b1, 9'h0, 44'h77778, F_USR), 27'h45670, 16'd5, 2'd0, 1'b0, "R12 install block");
      refill(mkpte(1'b0, 9'h0, 44'h999, F_USR), 27'h45000, 16'd5, 2'd0, 1'b0, "R12 install page");
      flush(1'b1, 27'h4567C, 1'b0, '0);
      lookup(27'h45671, 16'd5, 1'b0, '0, '0, "R12 page flush kills block");
      lookup(27'h45000, 16'd5, 1'b1, 44'h999, F_USR, "R12 page flush spares other");
      flush(1'b0, '0, 1'b0, '0);
      lookup(27'h45000, 16'd5, 1'b0, '0, '0, "R12 full flush");

      // R3 contiguity disabled
      b_refill(mkpte(1'b1, 9'h0, 44'hABCD8, F_USR), 27'h12340, 1'b1, "R3 N reserved");
      b_lookup(27'h12340, 1'b0, '0, "R3 not installed");
      b_refill(mkpte(1'b0, 9'h0, 44'hABCD8, F_USR), 27'h12340, 1'b0, "R3 plain page");
      b_lookup(27'h12341, 1'b0, '0, "R3 plain page no span");

      repeat (4) @(negedge clk);
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R1: %0d responses missing, expected 0", sb.size());
      end
      report();
      $finish;
   end

endmodule